// File: doc/BRIEF.md
# Tiled Glyph Pixel Pipeline

This block renders an on-screen text overlay one pixel per clock. A window generator elsewhere supplies local overlay coordinates. The screen is split into square cells of 16 by 16 pixels. The upper bits of the coordinates select a cell in a text memory, which returns a character code. That code, joined with the pixel's position inside the cell, addresses a glyph memory holding 2-bit pixel values. The 2-bit value then selects one of four colours in a small palette.

All three lookups are registered stages, and the in-cell position bits travel through a matching delay. A new coordinate is therefore accepted every clock, and its colour leaves after a fixed latency. The pipeline does no arithmetic on the coordinates. It never stalls and carries no valid flag: every stage moves on every clock, and invalid data simply flows out ahead of the first real pixel.

A host loads screen text, glyph shapes and colours through three independent write ports while the pipeline runs. When a write and a pipeline read hit the same location in the same cycle, the read returns the value held before the write.

Top module: `glyph_pixel_pipe`

## Requirements
- R1: While `rst` is high at a rising clock edge, `pix_color` is zero after that edge. Reset does not clear the text, glyph or palette contents.
- R2: The text memory entry read for a pixel has index `{osd_y[Y_W-1:4], osd_x[X_W-1:4]}`: the cell row sits in the upper bits and the cell column in the lower bits. This is also the index used by `txt_waddr`.
- R3: The colour for the coordinate present at rising edge k appears on `pix_color` after rising edge k+2, which is three registered stages. A new coordinate is accepted on every edge.
- R4: The glyph memory entry read for a pixel has index `{code, osd_y[3:0], osd_x[3:0]}`, with the character code in the top CODE_W bits and the in-cell row above the in-cell column. This is also the index used by `fnt_waddr`.
- R5: The 2-bit glyph value selects palette entry 0 to 3, and that entry's COLOR_W-bit word is driven on `pix_color`.
- R6: A text write to the entry that the pipeline reads at the same edge leaves that pixel with the old character code.
- R7: A glyph write to the entry that the pipeline reads at the same edge leaves that pixel with the old glyph value.
- R8: A palette write to the entry that the pipeline reads at the same edge leaves that pixel with the old colour.
- R9: Data written through any of the three write ports is used by every pipeline read that happens at a later edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset of the pipeline registers |
| osd_x | input | X_W (7) | Local overlay column of the pixel entering this clock |
| osd_y | input | Y_W (6) | Local overlay row of the pixel entering this clock |
| txt_we | input | 1 | Text memory write enable |
| txt_waddr | input | (X_W-4)+(Y_W-4) (5) | Text memory write index, laid out as in R2 |
| txt_wdata | input | CODE_W (3) | Character code to store |
| fnt_we | input | 1 | Glyph memory write enable |
| fnt_waddr | input | CODE_W+8 (11) | Glyph memory write index, laid out as in R4 |
| fnt_wdata | input | 2 | Glyph pixel value to store |
| pal_we | input | 1 | Palette write enable |
| pal_waddr | input | 2 | Palette entry to write |
| pal_wdata | input | COLOR_W (12) | Colour word to store |
| pix_color | output | COLOR_W (12) | Registered colour of the pixel that entered three clocks earlier |

## Verification
A coordinate driven before rising edge k is read from text memory at edge k, from glyph memory at edge k+1 and from the palette at edge k+2. Its colour is therefore due on `pix_color` three edges after it is presented. The bench drives inputs on falling edges and keeps a behavioural model that advances on each rising edge. It compares the output with the model on every falling edge, so each comparison falls on the first half-cycle in which the result is valid. Each collision test times its write to the exact edge at which the matching stage reads: the text write goes with the coordinate, the glyph write one clock later and the palette write two clocks later. The bench then checks the old-data colour three edges after the coordinate and checks the new-data colour after the coordinate is presented again.

// File: rtl/glyph_pipe_pkg.sv
`timescale 1ns/1ps
package glyph_pipe_pkg;
  // Cells are square, 2**CELL_LOG2 pixels per side.
  localparam int CELL_LOG2 = 4;
  // Bits of in-cell position carried beside the character code (row + column).
  localparam int SUB_W     = 2 * CELL_LOG2;
  // Glyph pixel depth and the palette it indexes.
  localparam int PIX_W     = 2;
  localparam int PAL_COUNT = 1 << PIX_W;

  typedef logic [PIX_W-1:0] pix_idx_t;
endpackage

// File: rtl/glyph_dp_ram.sv
`timescale 1ns/1ps
// Simple dual-port memory: one write port, one registered read port.
// The read returns the contents held before any write at the same edge.
module glyph_dp_ram #(
  parameter int AW = 5,
  parameter int DW = 3,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  // Output register with synchronous reset, as offered by block RAM.
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      rdata <= mem[raddr];
    end
  end
endmodule

// File: rtl/glyph_sub_delay.sv
`timescale 1ns/1ps
// Fixed-length delay line for the in-cell coordinate bits.
module glyph_sub_delay #(
  parameter int W      = 8,
  parameter int STAGES = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr <= '0;
    end else begin
      sr[0] <= din;
      for (int s = 1; s < STAGES; s++) begin
        sr[s] <= sr[s-1];
      end
    end
  end

  assign dout = sr[STAGES-1];
endmodule

// File: rtl/glyph_palette.sv
`timescale 1ns/1ps
// Small register-file palette with a registered read; old data on collision.
module glyph_palette #(
  parameter int CW      = 12,
  parameter int ENTRIES = 4,
  localparam int AW     = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [CW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [CW-1:0] rdata
);
  logic [CW-1:0] entry [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic [CW-1:0] val;
    always_ff @(posedge clk) begin
      if (we && (waddr == AW'(e))) begin
        val <= wdata;
      end
    end
    assign entry[e] = val;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      rdata <= entry[raddr];
    end
  end
endmodule

// File: rtl/glyph_pixel_pipe.sv
`timescale 1ns/1ps
// Three-stage text render pipeline: cell code -> glyph pixel -> colour.
module glyph_pixel_pipe
  import glyph_pipe_pkg::*;
#(
  parameter int X_W     = 7,
  parameter int Y_W     = 6,
  parameter int CODE_W  = 3,
  parameter int COLOR_W = 12,
  localparam int COL_W  = X_W - CELL_LOG2,
  localparam int ROW_W  = Y_W - CELL_LOG2,
  localparam int TXT_AW = ROW_W + COL_W,
  localparam int FNT_AW = CODE_W + SUB_W,
  localparam int PAL_AW = $clog2(PAL_COUNT)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [X_W-1:0]     osd_x,
  input  logic [Y_W-1:0]     osd_y,
  input  logic               txt_we,
  input  logic [TXT_AW-1:0]  txt_waddr,
  input  logic [CODE_W-1:0]  txt_wdata,
  input  logic               fnt_we,
  input  logic [FNT_AW-1:0]  fnt_waddr,
  input  logic [PIX_W-1:0]   fnt_wdata,
  input  logic               pal_we,
  input  logic [PAL_AW-1:0]  pal_waddr,
  input  logic [COLOR_W-1:0] pal_wdata,
  output logic [COLOR_W-1:0] pix_color
);
  // Stage 1: cell lookup, pure wiring of the upper coordinate bits.
  logic [TXT_AW-1:0] txt_raddr;
  logic [SUB_W-1:0]  sub_now;
  logic [SUB_W-1:0]  sub_dly;
  logic [CODE_W-1:0] char_code;

  assign txt_raddr = {osd_y[Y_W-1:CELL_LOG2], osd_x[X_W-1:CELL_LOG2]};
  assign sub_now   = {osd_y[CELL_LOG2-1:0], osd_x[CELL_LOG2-1:0]};

  glyph_dp_ram #(
    .AW (TXT_AW),
    .DW (CODE_W)
  ) u_text (
    .clk   (clk),
    .rst   (rst),
    .we    (txt_we),
    .waddr (txt_waddr),
    .wdata (txt_wdata),
    .raddr (txt_raddr),
    .rdata (char_code)
  );

  // In-cell position follows the text read by exactly one register.
  glyph_sub_delay #(
    .W      (SUB_W),
    .STAGES (1)
  ) u_sub (
    .clk  (clk),
    .rst  (rst),
    .din  (sub_now),
    .dout (sub_dly)
  );

  // Stage 2: glyph lookup.
  logic [FNT_AW-1:0] fnt_raddr;
  pix_idx_t          pix_idx;

  assign fnt_raddr = {char_code, sub_dly};

  glyph_dp_ram #(
    .AW (FNT_AW),
    .DW (PIX_W)
  ) u_font (
    .clk   (clk),
    .rst   (rst),
    .we    (fnt_we),
    .waddr (fnt_waddr),
    .wdata (fnt_wdata),
    .raddr (fnt_raddr),
    .rdata (pix_idx)
  );

  // Stage 3: colour lookup, registered output.
  glyph_palette #(
    .CW      (COLOR_W),
    .ENTRIES (PAL_COUNT)
  ) u_pal (
    .clk   (clk),
    .rst   (rst),
    .we    (pal_we),
    .waddr (pal_waddr),
    .wdata (pal_wdata),
    .raddr (pix_idx),
    .rdata (pix_color)
  );
endmodule

// File: rtl/glyph_pixel_pipe_chk.sv
`timescale 1ns/1ps
module glyph_pixel_pipe_chk #(
  parameter int X_W     = 7,
  parameter int Y_W     = 6,
  parameter int COLOR_W = 12
) (
  input logic               clk,
  input logic               rst,
  input logic [X_W-1:0]     osd_x,
  input logic [Y_W-1:0]     osd_y,
  input logic               txt_we,
  input logic               fnt_we,
  input logic               pal_we,
  input logic [1:0]         pal_waddr,
  input logic [COLOR_W-1:0] pal_wdata,
  input logic [1:0]         pix_idx,
  input logic [COLOR_W-1:0] pix_color
);
  logic               rst_q = 1'b0;
  logic [2:0]         quiet = '0;
  logic [X_W-1:0]     x_q   = '0;
  logic [Y_W-1:0]     y_q   = '0;
  logic [COLOR_W-1:0] shadow [4];

  always_ff @(posedge clk) begin
    rst_q <= rst;
    x_q   <= osd_x;
    y_q   <= osd_y;
    if (rst) begin
      quiet <= '0;
    end else if (!txt_we && !fnt_we && !pal_we && osd_x == x_q && osd_y == y_q) begin
      quiet <= (quiet == 3'd7) ? quiet : quiet + 3'd1;
    end else begin
      quiet <= '0;
    end
    if (pal_we) begin
      shadow[pal_waddr] <= pal_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_q) begin
      AST_RESET_BLACK: assert (pix_color == '0); // R1
    end
  end

  AST_HOLD_WHEN_QUIET: assert property (@(posedge clk) disable iff (rst)
    (quiet >= 3'd4) |-> $stable(pix_color)); // R3

  AST_PAL_OLD_ON_COLLIDE: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (pix_color == $past(shadow[pix_idx]))); // R8

  AST_PAL_NEW_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    pal_we ##1 (pix_idx == $past(pal_waddr)) |=> (pix_color == $past(pal_wdata, 2))); // R9
endmodule

bind glyph_pixel_pipe glyph_pixel_pipe_chk #(
  .X_W     (X_W),
  .Y_W     (Y_W),
  .COLOR_W (COLOR_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .osd_x     (osd_x),
  .osd_y     (osd_y),
  .txt_we    (txt_we),
  .fnt_we    (fnt_we),
  .pal_we    (pal_we),
  .pal_waddr (pal_waddr),
  .pal_wdata (pal_wdata),
  .pix_idx   (pix_idx),
  .pix_color (pix_color)
);

// File: tb/test_glyph_pixel_pipe.sv
`timescale 1ns/1ps
module test_glyph_pixel_pipe;
  localparam int X_W     = 7;
  localparam int Y_W     = 6;
  localparam int CODE_W  = 3;
  localparam int COLOR_W = 12;
  localparam int TXT_AW  = (X_W - 4) + (Y_W - 4);
  localparam int FNT_AW  = CODE_W + 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic               rst = 1'b1;
  logic [X_W-1:0]     osd_x = '0;
  logic [Y_W-1:0]     osd_y = '0;
  logic               txt_we = 1'b0;
  logic [TXT_AW-1:0]  txt_waddr = '0;
  logic [CODE_W-1:0]  txt_wdata = '0;
  logic               fnt_we = 1'b0;
  logic [FNT_AW-1:0]  fnt_waddr = '0;
  logic [1:0]         fnt_wdata = '0;
  logic               pal_we = 1'b0;
  logic [1:0]         pal_waddr = '0;
  logic [COLOR_W-1:0] pal_wdata = '0;
  logic [COLOR_W-1:0] pix_color;

  glyph_pixel_pipe #(
    .X_W (X_W), .Y_W (Y_W), .CODE_W (CODE_W), .COLOR_W (COLOR_W)
  ) i_glyph_pixel_pipe (
    .clk (clk), .rst (rst), .osd_x (osd_x), .osd_y (osd_y),
    .txt_we (txt_we), .txt_waddr (txt_waddr), .txt_wdata (txt_wdata),
    .fnt_we (fnt_we), .fnt_waddr (fnt_waddr), .fnt_wdata (fnt_wdata),
    .pal_we (pal_we), .pal_waddr (pal_waddr), .pal_wdata (pal_wdata),
    .pix_color (pix_color)
  );

  int    vectors = 0;
  int    errors  = 0;
  bit    done    = 1'b0;
  bit    cmp_on  = 1'b0;
  string req_tag = "R1";

  // Behavioural model: memory images plus the values in flight per stage.
  logic [CODE_W-1:0]  txt_m [2**TXT_AW];
  logic [1:0]         fnt_m [2**FNT_AW];
  logic [COLOR_W-1:0] pal_m [4];
  logic [CODE_W-1:0]  m_code  = '0;
  logic [7:0]         m_sub   = '0;
  logic [1:0]         m_pix   = '0;
  logic [COLOR_W-1:0] m_color = '0;

  function automatic logic [TXT_AW-1:0] cell_of(int x, int y);
    logic [X_W-1:0] xv = X_W'(x);
    logic [Y_W-1:0] yv = Y_W'(y);
    return {yv[Y_W-1:4], xv[X_W-1:4]};
  endfunction

  function automatic logic [FNT_AW-1:0] glyph_of(int x, int y);
    logic [X_W-1:0] xv = X_W'(x);
    logic [Y_W-1:0] yv = Y_W'(y);
    return {txt_m[cell_of(x, y)], yv[3:0], xv[3:0]};
  endfunction

  function automatic logic [COLOR_W-1:0] color_of(int x, int y);
    return pal_m[fnt_m[glyph_of(x, y)]];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_color = '0; m_pix = '0; m_sub = '0; m_code = '0;
    end else begin
      m_color = pal_m[m_pix];
      m_pix   = fnt_m[{m_code, m_sub}];
      m_sub   = {osd_y[3:0], osd_x[3:0]};
      m_code  = txt_m[cell_of(int'(osd_x), int'(osd_y))];
    end
    if (txt_we) txt_m[txt_waddr] = txt_wdata;
    if (fnt_we) fnt_m[fnt_waddr] = fnt_wdata;
    if (pal_we) pal_m[pal_waddr] = pal_wdata;
  end

  task automatic check(string tag, logic [COLOR_W-1:0] got, logic [COLOR_W-1:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: pix_color=%h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) check(req_tag, pix_color, m_color);
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  task automatic drive(int x, int y);
    @(negedge clk);
    osd_x  = X_W'(x);
    osd_y  = Y_W'(y);
    txt_we = 1'b0;
    fnt_we = 1'b0;
    pal_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run still active, expected completion");
    finish_run();
  end

  initial begin
    logic [COLOR_W-1:0] e_old;
    logic [COLOR_W-1:0] e_new;
    logic [FNT_AW-1:0]  fa;
    @(posedge clk);
    cmp_on  = 1'b1;
    // R1: load every memory while reset holds the output at zero.
    req_tag = "R1 reset";
    for (int i = 0; i < 2**FNT_AW; i++) begin
      drive(0, 0);
      fnt_we = 1'b1; fnt_waddr = FNT_AW'(i); fnt_wdata = 2'((i ^ (i >> 3) ^ (i >> 6)) & 3);
      if (i < 2**TXT_AW) begin
        txt_we = 1'b1; txt_waddr = TXT_AW'(i); txt_wdata = CODE_W'((i * 5 + 3) % 8);
      end
      if (i < 4) begin
        pal_we = 1'b1; pal_waddr = 2'(i); pal_wdata = COLOR_W'(12'h1A5 * (i + 1));
      end
    end
    drive(0, 0);
    drive(0, 0);
    check("R1 output zero under reset", pix_color, '0);
    rst = 1'b0;

    // R2 R3 R4 R5: full raster scan, one new pixel per clock.
    req_tag = "R2 R3 R4 R5 scan";
    for (int y = 0; y < 2**Y_W; y++) begin
      for (int x = 0; x < 2**X_W; x++) drive(x, y);
    end
    req_tag = "R3 column scan";
    for (int x = 0; x < 2**X_W; x += 3) begin
      for (int y = 0; y < 2**Y_W; y++) drive(x, y);
    end

    // R6: text write colliding with the read of the same cell.
    req_tag = "R6 collide";
    e_old = color_of(37, 21);
    drive(37, 21);
    txt_we = 1'b1; txt_waddr = cell_of(37, 21); txt_wdata = txt_m[cell_of(37, 21)] + 3'd1;
    drive(0, 0); drive(0, 0);
    @(negedge clk); check("R6 old code used", pix_color, e_old);
    e_new = color_of(37, 21);
    drive(37, 21); drive(0, 0); drive(0, 0);
    @(negedge clk); check("R9 new code used", pix_color, e_new);

    // R7: glyph write one clock later, hitting the glyph read of that pixel.
    req_tag = "R7 collide";
    e_old = color_of(50, 40);
    fa    = glyph_of(50, 40);
    drive(50, 40);
    drive(0, 0);
    fnt_we = 1'b1; fnt_waddr = fa; fnt_wdata = fnt_m[fa] ^ 2'd1;
    drive(0, 0);
    @(negedge clk); check("R7 old glyph value used", pix_color, e_old);
    e_new = color_of(50, 40);
    drive(50, 40); drive(0, 0); drive(0, 0);
    @(negedge clk); check("R9 new glyph value used", pix_color, e_new);

    // R8: palette write two clocks later, hitting the colour read.
    req_tag = "R8 collide";
    e_old = color_of(90, 9);
    drive(90, 9);
    drive(0, 0);
    drive(0, 0);
    pal_we = 1'b1; pal_waddr = fnt_m[glyph_of(90, 9)]; pal_wdata = ~e_old;
    @(negedge clk); check("R8 old colour used", pix_color, e_old);
    drive(90, 9); drive(0, 0); drive(0, 0);
    @(negedge clk); check("R9 new colour used", pix_color, ~e_old);

    // R3 R6 R7 R8 R9: random pixels with random concurrent host writes.
    req_tag = "R3 R6 R7 R8 R9 random";
    for (int n = 0; n < 4000; n++) begin
      drive(int'($urandom_range(2**X_W - 1)), int'($urandom_range(2**Y_W - 1)));
      if ($urandom_range(9) == 0) begin
        txt_we = 1'b1; txt_waddr = TXT_AW'($urandom); txt_wdata = CODE_W'($urandom);
      end
      if ($urandom_range(4) == 0) begin
        fnt_we = 1'b1; fnt_waddr = FNT_AW'($urandom); fnt_wdata = 2'($urandom);
      end
      if ($urandom_range(9) == 0) begin
        pal_we = 1'b1; pal_waddr = 2'($urandom); pal_wdata = COLOR_W'($urandom);
      end
    end

    // R1 again: reset in mid-stream forces black without erasing memories.
    req_tag = "R1 mid reset";
    drive(5, 5); rst = 1'b1;
    drive(5, 5); drive(5, 5);
    rst = 1'b0;
    req_tag = "R1 contents kept";
    e_old = color_of(70, 33);
    drive(70, 33); drive(0, 0); drive(0, 0);
    @(negedge clk); check("R1 memories survive reset", pix_color, e_old);
    drive(0, 0);
    cmp_on = 1'b0;
    finish_run();
  end
endmodule